// File: doc/BRIEF.md
# Mod/RM Effective Address Generator

This block turns the addressing fields of a two-byte operand specifier into either a 16-bit memory offset or a register-operand selector. The caller presents the two-bit mode field, the three-bit r/m field, the operand width bit, the two displacement bytes and the current contents of the four base and index registers, then pulses `start_i` for one cycle.

For a memory operand the block picks zero, one or two of the base and index registers according to r/m. It adds a displacement whose form depends on the mode: none, one byte sign-extended, or two bytes taken low byte first. One combination is special. It means a direct address: the two displacement bytes are the whole offset and no register takes part. For a register operand it reports the register code and width and drives the address to zero.

The result is registered. It appears together with a one-cycle `done_o` pulse on the clock edge that samples the start strobe. Segment arithmetic, the bus access and the register file itself are left to the surrounding pipeline.

Top module: `ea_resolver`

## Requirements
- R1: With mode 00, 01 or 10, r/m 000, 001, 010 and 011 give the sums BX+SI, BX+DI, BP+SI and BP+DI, plus the displacement.
- R2: With mode 00, 01 or 10, r/m 100 uses SI alone, 101 uses DI alone and 111 uses BX alone. With mode 01 or 10, r/m 110 uses BP alone. In each case the displacement is added.
- R3: Mode 00 with r/m 110 is a direct address. The offset is {disp_hi_i, disp_lo_i} and no register contributes.
- R4: Mode 00 with any other r/m adds no displacement. Both displacement bytes have no effect.
- R5: Mode 01 sign-extends disp_lo_i to 16 bits by copying its bit 7 (0xFC counts as -4) and adds it. disp_hi_i has no effect.
- R6: Mode 10 adds the 16-bit displacement {disp_hi_i, disp_lo_i}. For example, bytes 0x80 then 0x00 add +128.
- R7: Address sums wrap modulo 2^16. No carry or overflow is reported.
- R8: Mode 11 is a register operand. The result has is_reg_o=1 and addr_o=0, reg_idx_o equals the r/m code, and reg_wide_o equals wide_i. With reg_wide_o=0, codes 0..7 name AL, CL, DL, BL, AH, CH, DH and BH. With reg_wide_o=1 they name AX, CX, DX, BX, SP, BP, SI and DI. In memory modes is_reg_o, reg_idx_o and reg_wide_o are 0.
- R9: The clock edge that samples start_i high loads the result and raises done_o for exactly that one cycle. Without start_i the outputs hold their values, whatever the inputs do.
- R10: While rst_n is low at a clock edge, every output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Sample the fields and compute |
| mod_i | input | 2 | Mode field |
| rm_i | input | 3 | r/m field |
| wide_i | input | 1 | Operand width: 0 byte, 1 word |
| disp_lo_i | input | 8 | First displacement byte (low) |
| disp_hi_i | input | 8 | Second displacement byte (high) |
| bx_i | input | 16 | BX contents |
| bp_i | input | 16 | BP contents |
| si_i | input | 16 | SI contents |
| di_i | input | 16 | DI contents |
| addr_o | output | 16 | Effective offset, 0 for register operands |
| is_reg_o | output | 1 | Operand is a register |
| reg_idx_o | output | 3 | Register code |
| reg_wide_o | output | 1 | Register width |
| done_o | output | 1 | Result valid pulse |

## Verification
The bench builds the block with its default widths: 16-bit addresses, 8-bit displacement bytes and 3-bit register codes. At these values the wrap at 2^16 and the sign-extension boundary between 0x7F and 0x80 can be reached directly with all-ones register values. The directed cases cover each r/m code, the direct-address exception and the ignored displacement bytes. A random phase then drives all four modes with arbitrary register contents, including back-to-back strobes. Hold checks change every input while the strobe is low and look at the outputs.

// File: rtl/ea_pkg.sv
// Shared types for the effective address generator.
// Assumes the classic 16-bit layout: two displacement bytes form one address word.
package ea_pkg;

    // Mode field encodings
    typedef enum logic [1:0] {
        MODE_NODISP = 2'b00,
        MODE_DISP8  = 2'b01,
        MODE_DISP16 = 2'b10,
        MODE_REG    = 2'b11
    } ea_mode_e;

    // Which registers contribute to a memory address
    typedef struct packed {
        logic take_bx;
        logic take_bp;
        logic take_si;
        logic take_di;
    } ea_terms_t;

    // Maps r/m and mode to the contributing registers (direct address takes none)
    function automatic ea_terms_t decode_terms(input logic [2:0] rm, input ea_mode_e mode);
        ea_terms_t t;
        t = '0;
        unique case (rm)
            3'd0: begin t.take_bx = 1'b1; t.take_si = 1'b1; end
            3'd1: begin t.take_bx = 1'b1; t.take_di = 1'b1; end
            3'd2: begin t.take_bp = 1'b1; t.take_si = 1'b1; end
            3'd3: begin t.take_bp = 1'b1; t.take_di = 1'b1; end
            3'd4: t.take_si = 1'b1;
            3'd5: t.take_di = 1'b1;
            3'd6: t.take_bp = (mode != MODE_NODISP);
            default: t.take_bx = 1'b1;
        endcase
        return t;
    endfunction

    // True for the direct-address combination
    function automatic logic is_direct(input logic [2:0] rm, input ea_mode_e mode);
        return (mode == MODE_NODISP) && (rm == 3'd6);
    endfunction

endpackage

// File: rtl/ea_term_select.sv
// Picks the base term (BX, BP or zero) and the index term (SI, DI or zero)
// for a memory operand. Purely combinational; assumes mode is not register.
module ea_term_select
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [2:0]        rm_i,
    input  ea_mode_e          mode_i,
    input  logic [ADDR_W-1:0] bx_i,
    input  logic [ADDR_W-1:0] bp_i,
    input  logic [ADDR_W-1:0] si_i,
    input  logic [ADDR_W-1:0] di_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] index_o,
    output logic              direct_o
);

    ea_terms_t terms;

    // Decode which registers take part
    always_comb terms = decode_terms(rm_i, mode_i);

    // Base multiplexer: BX and BP are mutually exclusive
    always_comb begin
        base_o = '0;
        if (terms.take_bx) base_o = bx_i;
        else if (terms.take_bp) base_o = bp_i;
    end

    // Index multiplexer: SI and DI are mutually exclusive
    always_comb begin
        index_o = '0;
        if (terms.take_si) index_o = si_i;
        else if (terms.take_di) index_o = di_i;
    end

    // Direct-address flag for the displacement former
    always_comb direct_o = is_direct(rm_i, mode_i);

endmodule

// File: rtl/ea_disp_form.sv
// Forms the 16-bit displacement term from the two displacement bytes.
// Mode 01 sign-extends the low byte; mode 10 and direct use both bytes.
module ea_disp_form
    import ea_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DISP_W = 2 * BYTE_W
) (
    input  ea_mode_e          mode_i,
    input  logic              direct_i,
    input  logic [BYTE_W-1:0] lo_i,
    input  logic [BYTE_W-1:0] hi_i,
    output logic [DISP_W-1:0] disp_o
);

    logic [DISP_W-1:0] sext_w;
    logic [DISP_W-1:0] full_w;

    // Sign extension: copy the top bit of the low byte into every upper bit
    genvar k;
    generate
        for (k = 0; k < DISP_W; k++) begin : g_sext
            if (k < BYTE_W) begin : g_low
                assign sext_w[k] = lo_i[k];
            end else begin : g_up
                assign sext_w[k] = lo_i[BYTE_W-1];
            end
        end
    endgenerate

    assign full_w = {hi_i, lo_i};

    // Choose the displacement by mode
    always_comb begin
        unique case (mode_i)
            MODE_DISP8:  disp_o = sext_w;
            MODE_DISP16: disp_o = full_w;
            MODE_NODISP: disp_o = direct_i ? full_w : '0;
            default:     disp_o = '0;
        endcase
    end

endmodule

// File: rtl/ea_operand_reg.sv
// Register-operand path: flags mode 11 and passes the register code and width.
// Outputs are zero for memory operands.
module ea_operand_reg
    import ea_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  ea_mode_e         mode_i,
    input  logic [IDX_W-1:0] rm_i,
    input  logic             wide_i,
    output logic             is_reg_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             wide_o
);

    // Register selector decode
    always_comb begin
        is_reg_o = (mode_i == MODE_REG);
        idx_o    = is_reg_o ? rm_i : '0;
        wide_o   = is_reg_o & wide_i;
    end

endmodule

// File: rtl/ea_resolver.sv
// Effective address generator top. Combines the base, index and displacement
// terms with a wrapping adder and registers the result on start_i.
// Assumes ADDR_W == 2*BYTE_W and synchronous active-low reset.
module ea_resolver
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mod_i,
    input  logic [IDX_W-1:0]  rm_i,
    input  logic              wide_i,
    input  logic [BYTE_W-1:0] disp_lo_i,
    input  logic [BYTE_W-1:0] disp_hi_i,
    input  logic [ADDR_W-1:0] bx_i,
    input  logic [ADDR_W-1:0] bp_i,
    input  logic [ADDR_W-1:0] si_i,
    input  logic [ADDR_W-1:0] di_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              is_reg_o,
    output logic [IDX_W-1:0]  reg_idx_o,
    output logic              reg_wide_o,
    output logic              done_o
);

    localparam int DISP_W = 2 * BYTE_W;

    ea_mode_e          mode_c;
    logic [ADDR_W-1:0] base_c;
    logic [ADDR_W-1:0] index_c;
    logic [DISP_W-1:0] disp_c;
    logic              direct_c;
    logic [ADDR_W-1:0] sum_c;
    logic              is_reg_c;
    logic [IDX_W-1:0]  idx_c;
    logic              wide_c;

    // Cast the raw mode field to its enum
    always_comb mode_c = ea_mode_e'(mod_i);

    ea_term_select #(.ADDR_W(ADDR_W)) u_terms (
        .rm_i     (rm_i),
        .mode_i   (mode_c),
        .bx_i     (bx_i),
        .bp_i     (bp_i),
        .si_i     (si_i),
        .di_i     (di_i),
        .base_o   (base_c),
        .index_o  (index_c),
        .direct_o (direct_c)
    );

    ea_disp_form #(.BYTE_W(BYTE_W), .DISP_W(DISP_W)) u_disp (
        .mode_i   (mode_c),
        .direct_i (direct_c),
        .lo_i     (disp_lo_i),
        .hi_i     (disp_hi_i),
        .disp_o   (disp_c)
    );

    ea_operand_reg #(.IDX_W(IDX_W)) u_opreg (
        .mode_i   (mode_c),
        .rm_i     (rm_i),
        .wide_i   (wide_i),
        .is_reg_o (is_reg_c),
        .idx_o    (idx_c),
        .wide_o   (wide_c)
    );

    // Three-term adder, truncated so the sum wraps modulo 2^ADDR_W
    always_comb sum_c = base_c + index_c + ADDR_W'(disp_c);

    // Result register: load on start, pulse done, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o     <= '0;
            is_reg_o   <= 1'b0;
            reg_idx_o  <= '0;
            reg_wide_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            done_o <= start_i;
            if (start_i) begin
                addr_o     <= is_reg_c ? '0 : sum_c;
                is_reg_o   <= is_reg_c;
                reg_idx_o  <= idx_c;
                reg_wide_o <= wide_c;
            end
        end
    end

    // R9: a strobe is answered by done on the next cycle
    a_r9_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R9: done never appears without a strobe one cycle earlier
    a_r9_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i));

    // R9: without a strobe the address holds
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(addr_o) && $stable(is_reg_o));

    // R8: register operands carry a zero address and the r/m code
    a_r8_reg_result: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mod_i == 2'b11) |=> (is_reg_o && addr_o == '0 && reg_idx_o == $past(rm_i)));

    // R3: direct address is the two displacement bytes alone
    a_r3_direct_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mod_i == 2'b00 && rm_i == 3'd6) |=> addr_o == $past({disp_hi_i, disp_lo_i}));

endmodule

// File: tb/ea_resolver_bench.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module ea_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  mod_i = '0;
    logic [2:0]  rm_i = '0;
    logic        wide_i = 1'b0;
    logic [7:0]  disp_lo_i = '0;
    logic [7:0]  disp_hi_i = '0;
    logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
    logic [15:0] addr_o;
    logic        is_reg_o;
    logic [2:0]  reg_idx_o;
    logic        reg_wide_o;
    logic        done_o;

    int checks = 0;
    int failures = 0;

    typedef struct packed {
        logic [15:0] addr;
        logic        is_reg;
        logic [2:0]  idx;
        logic        wide;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  last_exp = '0;

    always #10 clk = ~clk;   // 50 MHz

    ea_resolver u_ea_resolver (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mod_i(mod_i), .rm_i(rm_i),
        .wide_i(wide_i), .disp_lo_i(disp_lo_i), .disp_hi_i(disp_hi_i),
        .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .addr_o(addr_o), .is_reg_o(is_reg_o), .reg_idx_o(reg_idx_o),
        .reg_wide_o(reg_wide_o), .done_o(done_o)
    );

    // Reference model written from the requirements
    function automatic exp_t model(logic [1:0] md, logic [2:0] rm, logic w,
                                   logic [7:0] lo, logic [7:0] hi,
                                   logic [15:0] bx, logic [15:0] bp,
                                   logic [15:0] si, logic [15:0] di);
        exp_t e;
        logic [15:0] d, b;
        e = '0;
        if (md == 2'b11) begin
            e.is_reg = 1'b1; e.idx = rm; e.wide = w; e.addr = 16'h0;
            return e;
        end
        if (md == 2'b00 && rm == 3'd6) begin
            e.addr = {hi, lo};
            return e;
        end
        case (md)
            2'b01:   d = {{8{lo[7]}}, lo};
            2'b10:   d = {hi, lo};
            default: d = 16'h0;
        endcase
        case (rm)
            3'd0: b = bx + si;
            3'd1: b = bx + di;
            3'd2: b = bp + si;
            3'd3: b = bp + di;
            3'd4: b = si;
            3'd5: b = di;
            3'd6: b = bp;
            default: b = bx;
        endcase
        e.addr = b + d;
        return e;
    endfunction

    // Driver: apply one request and queue its expected result; leaves start high
    task automatic issue(logic [1:0] md, logic [2:0] rm, logic w, logic [7:0] lo,
                         logic [7:0] hi, logic [15:0] bx, logic [15:0] bp,
                         logic [15:0] si, logic [15:0] di, string tag);
        mod_i = md; rm_i = rm; wide_i = w; disp_lo_i = lo; disp_hi_i = hi;
        bx_i = bx; bp_i = bp; si_i = si; di_i = di; start_i = 1'b1;
        exp_q.push_back(model(md, rm, w, lo, hi, bx, bp, si, di));
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        start_i = 1'b0;
        @(negedge clk);
    endtask

    // Compare one outcome
    task automatic check(string tag, exp_t act, exp_t exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual addr=%h reg=%b idx=%0d wide=%b expected addr=%h reg=%b idx=%0d wide=%b",
                     tag, act.addr, act.is_reg, act.idx, act.wide,
                     exp.addr, exp.is_reg, exp.idx, exp.wide);
        end
    endtask

    // Monitor: on every done pulse pop and compare the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R9: actual done=1 expected done=0 (no request pending)");
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {addr_o, is_reg_o, reg_idx_o, reg_wide_o}, e);
                    last_exp = e;
                end
            end
        end
    end

    // Hold check: scramble inputs with start low and confirm nothing moves (R9, R4-style ignore)
    task automatic hold_check();
        for (int i = 0; i < 3; i++) begin
            mod_i = 2'($urandom); rm_i = 3'($urandom); wide_i = 1'($urandom);
            disp_lo_i = 8'($urandom); disp_hi_i = 8'($urandom);
            bx_i = 16'($urandom); bp_i = 16'($urandom);
            si_i = 16'($urandom); di_i = 16'($urandom);
            @(negedge clk);
            check("R9 hold", {addr_o, is_reg_o, reg_idx_o, reg_wide_o}, last_exp);
            checks++;
            if (done_o !== 1'b0) begin
                failures++;
                $display("FAIL R9: actual done=%b expected done=0 while idle", done_o);
            end
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Stimulus
    initial begin
        // R10: reset with inputs active
        start_i = 1'b1; mod_i = 2'b10; bx_i = 16'h1234;
        repeat (3) @(negedge clk);
        check("R10 reset", {addr_o, is_reg_o, reg_idx_o, reg_wide_o}, '0);
        checks++;
        if (done_o !== 1'b0) begin
            failures++;
            $display("FAIL R10: actual done=%b expected done=0", done_o);
        end
        start_i = 1'b0; bx_i = '0; mod_i = '0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 pairs
        issue(2'b00, 3'd0, 1'b0, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h0234, 16'h0567, "R1 bx+si"); idle();
        issue(2'b00, 3'd1, 1'b0, 8'h00, 8'h00, 16'h1000, 16'h2000, 16'h0234, 16'h0567, "R1 bx+di"); idle();
        issue(2'b01, 3'd2, 1'b1, 8'h10, 8'h00, 16'h1000, 16'h2000, 16'h0234, 16'h0567, "R1 bp+si+d8"); idle();
        issue(2'b10, 3'd3, 1'b1, 8'h10, 8'h01, 16'h1000, 16'h2000, 16'h0234, 16'h0567, "R1 bp+di+d16"); idle();
        // R2 singles
        issue(2'b00, 3'd4, 1'b0, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R2 si"); idle();
        issue(2'b00, 3'd5, 1'b0, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R2 di"); idle();
        issue(2'b01, 3'd6, 1'b0, 8'h05, 8'h00, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R2 bp+5"); idle();
        issue(2'b00, 3'd7, 1'b0, 8'h00, 8'h00, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R2 bx"); idle();
        // R3 direct address
        issue(2'b00, 3'd6, 1'b1, 8'h00, 8'h02, 16'h1111, 16'h2222, 16'h3333, 16'h4444, "R3 direct"); idle();
        // R4 displacement bytes ignored in mode 00
        issue(2'b00, 3'd7, 1'b1, 8'hAB, 8'hCD, 16'h0800, 16'h2222, 16'h3333, 16'h4444, "R4 no disp"); idle();
        // R5 sign extension: 0xFC = -4, high byte ignored
        issue(2'b01, 3'd4, 1'b0, 8'hFC, 8'h77, 16'h0, 16'h0, 16'h0100, 16'h0, "R5 minus4"); idle();
        issue(2'b01, 3'd4, 1'b0, 8'h7F, 8'hFF, 16'h0, 16'h0, 16'h0100, 16'h0, "R5 plus127"); idle();
        issue(2'b01, 3'd4, 1'b0, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0100, 16'h0, "R5 minus128"); idle();
        // R6 +128 needs two bytes
        issue(2'b10, 3'd4, 1'b0, 8'h80, 8'h00, 16'h0, 16'h0, 16'h0100, 16'h0, "R6 plus128"); idle();
        // R7 wrap
        issue(2'b10, 3'd0, 1'b1, 8'hFF, 8'hFF, 16'hFFFF, 16'h0, 16'h0002, 16'h0, "R7 wrap"); idle();
        issue(2'b01, 3'd0, 1'b1, 8'hFE, 8'h00, 16'h0001, 16'h0, 16'h0000, 16'h0, "R7 underflow"); idle();
        // R8 register operands
        issue(2'b11, 3'd6, 1'b0, 8'h12, 8'h34, 16'h1, 16'h2, 16'h3, 16'h4, "R8 byte DH"); idle();
        issue(2'b11, 3'd7, 1'b1, 8'h12, 8'h34, 16'h1, 16'h2, 16'h3, 16'h4, "R8 word DI"); idle();
        // R9 back-to-back strobes, then hold
        issue(2'b10, 3'd1, 1'b1, 8'h02, 8'h00, 16'h0100, 16'h0, 16'h0, 16'h0010, "R9 b2b first");
        issue(2'b11, 3'd2, 1'b1, 8'h00, 8'h00, 16'h0, 16'h0, 16'h0, 16'h0, "R9 b2b second");
        issue(2'b00, 3'd6, 1'b0, 8'h34, 8'h12, 16'h0, 16'h0, 16'h0, 16'h0, "R9 b2b third");
        idle(); idle();
        hold_check();
        // Random sweep over all modes
        for (int n = 0; n < 300; n++) begin
            issue(2'($urandom), 3'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), "R1 R2 R5 R6 R8 random");
            if (n % 3 == 0) idle();
        end
        idle(); idle();
        hold_check();
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R9: actual pending=%0d expected pending=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule